// File: doc/BRIEF.md
# Two-Channel Address Breakpoint Unit

The unit watches the memory-access stream of a processor core. Two comparison channels, A and B, each hold a compare address, a don't-care mask and a set of permitted access kinds. An access is either an instruction fetch, including a fetch at a branch target, or an operand access. An operand access stays an operand access even when it is a PC-relative load close to the program counter. When a channel matches, the unit raises a one-cycle break request toward the core.

A control register chooses between two modes. In independent mode each channel breaks on its own. In sequential mode a channel A match only arms channel B. The control register also chooses when a channel B fetch match takes effect: before the matched instruction runs, or after the core reports that it has retired. A debug-enable bit steers each break to either the normal core output or the debug-support output. The compare, mask, kind, control and status registers are reached through a simple eight-entry register port.

Top module: `dual_break_unit`

## Requirements
- R1: Channel X matches on an access when `acc_valid` is 1, every address bit whose mask bit is 0 equals the compare bit, and the access kind is enabled in its kind field. Kind field bit 0 enables fetches (`acc_fetch`=1) and bit 1 enables operand accesses (`acc_fetch`=0).
- R2: With control bit 1 (sequence) clear, a match on either channel drives a break output high for exactly the cycle after the clock edge that sampled the access.
- R3: With control bit 1 set, a channel A match raises no break and sets the armed flag (status bit 2). A channel B match breaks only while armed, and doing so clears the flag.
- R4: Any write to the control register (select 6) clears the armed flag.
- R5: With control bit 2 (late) set, a channel B fetch match raises no immediate break. The break is held pending and goes high for exactly the one cycle after the edge that samples `retire`=1. Channel B operand matches still break immediately.
- R6: With control bit 0 (debug enable) set, breaks appear only on `brk_dbg`. With it clear, they appear only on `brk_core`.
- R7: Reset clears debug enable, the compare, mask and kind registers, the status flags, the armed flag and any pending break. The sequence and late control bits keep their values through reset.
- R8: Control register bits above bit 2 read as 0 whatever was written.
- R9: Status (select 7) bit 0 marks channel A and bit 1 marks channel B as the cause of the latest break, and both are rewritten on each break. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or manual) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 A compare, 1 A mask, 2 B compare, 3 B mask, 4 A kind, 5 B kind, 6 control, 7 status |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Read data of the selected register |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | AW | Access address |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| retire | input | 1 | Core reports that the instruction matched earlier has retired |
| brk_core | output | 1 | Break request to the core |
| brk_dbg | output | 1 | Break request to the debug-support path |

## Verification
The assertions assume that `retire` is only raised after a channel B fetch match has been deferred. They also assume that the sequence bit has been written before the first access after power-up, because that bit has no reset value. The stimulus writes the control register first and pulses `retire` only while a break is pending. The sweeps touch one channel at a time, with the other channel's kind field at zero, so every break has a single known cause.

// File: rtl/dual_break_unit.sv
module dual_break_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_fetch,
  input  logic          retire,
  output logic          brk_core,
  output logic          brk_dbg
);
  logic [AW-1:0] a_cmp, a_msk, b_cmp, b_msk;
  logic [1:0]    a_kind, b_kind;
  logic          dbg_en, seq_mode, b_after;
  logic          st_a, st_b, armed, pend;

  wire [1:0] acc_kind = acc_fetch ? 2'b01 : 2'b10;
  wire hit_a = acc_valid && (((acc_addr ^ a_cmp) & ~a_msk) == '0) && |(a_kind & acc_kind);
  wire hit_b = acc_valid && (((acc_addr ^ b_cmp) & ~b_msk) == '0) && |(b_kind & acc_kind);

  wire b_take      = hit_b && (!seq_mode || armed);
  wire pend_set    = b_take && b_after && acc_fetch;
  wire fire_a      = hit_a && !seq_mode;
  wire fire_b_now  = b_take && !(b_after && acc_fetch);
  wire fire_b_late = pend && retire;
  wire fire        = fire_a || fire_b_now || fire_b_late;

  wire ctl_wr = reg_wr && (reg_sel == 3'd6);
  wire st_wr  = reg_wr && (reg_sel == 3'd7);

  always_ff @(posedge clk) begin
    if (ctl_wr) {b_after, seq_mode} <= reg_wdata[2:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cmp <= '0; a_msk <= '0; b_cmp <= '0; b_msk <= '0;
      a_kind <= '0; b_kind <= '0; dbg_en <= 1'b0;
      st_a <= 1'b0; st_b <= 1'b0; armed <= 1'b0; pend <= 1'b0;
      brk_core <= 1'b0; brk_dbg <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          3'd0: a_cmp  <= reg_wdata;
          3'd1: a_msk  <= reg_wdata;
          3'd2: b_cmp  <= reg_wdata;
          3'd3: b_msk  <= reg_wdata;
          3'd4: a_kind <= reg_wdata[1:0];
          3'd5: b_kind <= reg_wdata[1:0];
          3'd6: dbg_en <= reg_wdata[0];
          default: ;
        endcase
      end

      if (ctl_wr)                 armed <= 1'b0;
      else if (hit_a && seq_mode) armed <= 1'b1;
      else if (b_take)            armed <= 1'b0;

      if (pend_set)         pend <= 1'b1;
      else if (fire_b_late) pend <= 1'b0;

      if (fire) begin
        st_a <= fire_a;
        st_b <= fire_b_now || fire_b_late;
      end else if (st_wr) begin
        st_a <= st_a && reg_wdata[0];
        st_b <= st_b && reg_wdata[1];
      end

      brk_core <= fire && !dbg_en;
      brk_dbg  <= fire && dbg_en;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      3'd0: reg_rdata = a_cmp;
      3'd1: reg_rdata = a_msk;
      3'd2: reg_rdata = b_cmp;
      3'd3: reg_rdata = b_msk;
      3'd4: reg_rdata[1:0] = a_kind;
      3'd5: reg_rdata[1:0] = b_kind;
      3'd6: reg_rdata[2:0] = {b_after, seq_mode, dbg_en};
      default: reg_rdata[2:0] = {armed, st_b, st_a};
    endcase
  end
endmodule

module dual_break_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_sel,
  input logic [AW-1:0] reg_rdata,
  input logic          retire,
  input logic          brk_core,
  input logic          brk_dbg,
  input logic          hit_a,
  input logic          hit_b,
  input logic          seq_mode,
  input logic          dbg_en,
  input logic          armed,
  input logic          pend,
  input logic          pend_set
);
  assert_route_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_core && brk_dbg));
  assert_dbg_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_dbg |-> $past(dbg_en));
  assert_core_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_core |-> !$past(dbg_en));
  assert_ctl_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd6) |=> !armed);
  assert_seq_a_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && hit_a && !hit_b && !(pend && retire)) |=> !(brk_core || brk_dbg));
  assert_late_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && retire && !pend_set) |=> ((brk_core || brk_dbg) && !pend));
  assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 3'd6) |-> (reg_rdata[AW-1:3] == '0));
endmodule

bind dual_break_unit dual_break_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .retire(retire), .brk_core(brk_core),
  .brk_dbg(brk_dbg), .hit_a(hit_a), .hit_b(hit_b), .seq_mode(seq_mode),
  .dbg_en(dbg_en), .armed(armed), .pend(pend), .pend_set(pend_set)
);

// File: tb/dual_break_unit_tb.sv
module dual_break_unit_tb;
  localparam int AW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0, reg_rdata;
  logic acc_valid = 1'b0, acc_fetch = 1'b0, retire = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic brk_core, brk_dbg;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_break_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_fetch(acc_fetch), .retire(retire),
    .brk_core(brk_core), .brk_dbg(brk_dbg)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel[2:0]; reg_wdata = data[AW-1:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input int sel, input int exp);
    @(negedge clk);
    reg_sel = sel[2:0];
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  // one access; returns {brk_dbg, brk_core} seen the cycle after the sampling edge
  task automatic acc(input int addr, input bit fetch, output int brk);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = addr[AW-1:0]; acc_fetch = fetch;
    @(negedge clk);
    acc_valid = 1'b0;
    brk = {brk_dbg, brk_core};
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    chk("R7 brk after reset", {brk_dbg, brk_core}, 0);
    rd("R7 status reset", 7, 0);
    rd("R7 a_kind reset", 4, 0);
    wr(6, 0);
    rd("R7 ctl after write", 6, 0);

    // R1 sweep on channel A, independent mode
    wr(0, 16'h1230); wr(1, 16'h000C); wr(5, 0);
    for (int k = 0; k < 4; k++) begin
      wr(4, k);
      for (int f = 0; f < 2; f++)
        for (int off = 0; off < 8; off++) begin
          bit exp_hit;
          exp_hit = ((off & ~12) == 0) && (f ? k[0] : k[1]);
          acc(16'h1230 ^ off, f[0], b);
          chk($sformatf("R1 kind=%0d f=%0d off=%0d", k, f, off), b, exp_hit ? 1 : 0);
        end
    end

    // R2 channel B independent, status R9
    wr(4, 0); wr(2, 16'h4400); wr(3, 0); wr(5, 3);
    acc(16'h4400, 1'b0, b); chk("R2 B immediate", b, 1);
    @(negedge clk); chk("R2 one cycle", {brk_dbg, brk_core}, 0);
    rd("R9 status B cause", 7, 2);
    acc(16'h4401, 1'b0, b); chk("R2 B miss", b, 0);

    // R3 sequential
    wr(4, 3); wr(1, 0);
    wr(6, 2);
    acc(16'h4400, 1'b0, b); chk("R3 B before arm", b, 0);
    acc(16'h1230, 1'b0, b); chk("R3 A silent", b, 0);
    rd("R3 armed set", 7, 6);
    acc(16'h4400, 1'b1, b); chk("R3 B armed break", b, 1);
    rd("R3 disarmed, B cause", 7, 2);
    acc(16'h4400, 1'b1, b); chk("R3 B after disarm", b, 0);

    // R4 control write disarms
    acc(16'h1230, 1'b1, b);
    rd("R4 armed before write", 7, 6);
    wr(6, 2);
    rd("R4 disarmed by write", 7, 2);
    acc(16'h4400, 1'b1, b); chk("R4 B no break", b, 0);

    // R5 late break on B fetch
    wr(6, 4); wr(4, 0);
    acc(16'h4400, 1'b1, b); chk("R5 no immediate", b, 0);
    repeat (3) @(negedge clk);
    chk("R5 held", {brk_dbg, brk_core}, 0);
    retire = 1'b1;
    @(negedge clk); retire = 1'b0;
    chk("R5 fires after retire", {brk_dbg, brk_core}, 1);
    @(negedge clk);
    chk("R5 single cycle", {brk_dbg, brk_core}, 0);
    acc(16'h4400, 1'b0, b); chk("R5 operand immediate", b, 1);

    // R6 routing
    wr(6, 1); wr(5, 0); wr(4, 3);
    acc(16'h1230, 1'b0, b); chk("R6 to debug", b, 2);
    wr(6, 0);
    acc(16'h1230, 1'b0, b); chk("R6 to core", b, 1);

    // R9 status clear semantics (A cause now)
    rd("R9 status A cause", 7, 1);
    wr(7, 1); rd("R9 write 1 keeps", 7, 1);
    wr(7, 0); rd("R9 write 0 clears", 7, 0);

    // R8 reserved bits
    wr(6, 16'hFFFF);
    rd("R8 reserved read zero", 6, 7);

    // R7 retention through reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd("R7 seq/late kept, dbg cleared", 6, 6);
    rd("R7 a_cmp cleared", 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule